// File: doc/BRIEF.md
# Fully Associative Page Cache

This block sits between a processor and a slower word-addressed central memory. Memory is viewed as pages of `2^OFFS_W` consecutive words. Each of the `UNITS` storage units keeps one whole page and the number of that page. On every request, the page-number field of the address is compared against all resident page numbers at once, with one comparator per unit.

A request that hits is served from the cache and never reaches memory. A miss stalls the processor. The block then picks a victim unit. If the victim holds modified data, it writes that page back to memory as a burst. It then reads the requested page in as a burst. Once the fill completes, the stalled request hits and is accepted. Writes change only the cached copy and mark the unit dirty.

Units that have never been filled are used first. After that, the victim is always the page that was loaded longest ago, however recently it was used. A pair of hit and miss counters lets the hit rate be observed.

Top module: `pc_page_cache`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, every unit is empty, both counters read zero, `rsp_valid_o` and `mem_valid_o` are low, and any request misses.
- R2: The page number is address bits `[ADDR_W-1:OFFS_W]` and the word within the page is bits `[OFFS_W-1:0]`. A read returns the latest value written to that word address, or the memory contents if it was never written. A write's response echoes the written word.
- R3: A request whose page is resident sees `req_ready_o` high in the same cycle, gets `rsp_valid_o` one cycle after acceptance, and causes no memory traffic. At most one unit matches any page number.
- R4: A request whose page is not resident sees `req_ready_o` low, and `req_ready_o` stays low while `mem_valid_o` is high. Exactly one read command (`mem_we_o` low) is issued at the page base address (low `OFFS_W` bits zero). `2^OFFS_W` data beats on `mem_rvalid_i` fill the unit, and then the request is accepted.
- R5: Empty units are filled before any page is evicted. Once all units are full, the victim is the page that was loaded earliest, even if it hit recently.
- R6: A write hit updates only the cached word, marks the unit dirty, and produces no memory access.
- R7: Before a dirty victim is refilled, its page is written back as `2^OFFS_W` write beats (`mem_we_o` high) at addresses page base + 0, 1, ... in order, carrying its current cached words. All of these beats come before the read command.
- R8: A clean victim is replaced without any write beats.
- R9: `hit_cnt_o` increments once for each request accepted without a preceding miss. `miss_cnt_o` increments once per miss. Neither counter moves by more than one per cycle.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, the command, address and write data are held unchanged. Gaps in `mem_rvalid_i` only delay the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor request valid, held until accepted |
| req_ready_o | output | 1 | Request accepted this cycle (resident page, idle) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | WORD_W | Write data |
| rsp_valid_o | output | 1 | Response one cycle after acceptance |
| rsp_rdata_o | output | WORD_W | Read word, or echoed write word |
| mem_valid_o | output | 1 | Memory command or write beat valid |
| mem_ready_i | input | 1 | Memory accepts the current command or beat |
| mem_we_o | output | 1 | 1 = write-back beat, 0 = page read command |
| mem_addr_o | output | ADDR_W | Beat address (write) or page base (read) |
| mem_wdata_o | output | WORD_W | Write-back beat data |
| mem_rvalid_i | input | 1 | Fill data beat valid |
| mem_rdata_i | input | WORD_W | Fill data beat, in ascending word order |
| hit_cnt_o | output | CNT_W | Hit counter |
| miss_cnt_o | output | CNT_W | Miss counter |

## Verification
The bench fills every unit, hits the oldest page, and then forces a miss. An LRU policy would evict a different page here, so the follow-up access to the first page would hit when it must miss. A dirty page is evicted and read back. A design that skipped the write-back, wrote stale words, or issued the fill read before the last write beat would return wrong data or fail the beat-order check. The memory side stalls `mem_ready_i` and leaves gaps in `mem_rvalid_i`. A design that advanced its beat counter without a handshake, or changed the address under a stall, would scramble pages or fail the hold check. A long mixed read/write run is compared against a queue-based model of resident pages, which exposes counter drift and replay hits that are wrongly counted as hits.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FREQ = 2'd2,
    ST_FILL = 2'd3
  } pc_state_e;
endpackage

// File: rtl/pc_tag_match.sv
`timescale 1ns/1ps
module pc_tag_match #(
  parameter int UNITS = 4,
  parameter int PN_W  = 6,
  parameter int IDX_W = $clog2(UNITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [UNITS-1:0][PN_W-1:0]  tags_i,
  input  logic [UNITS-1:0]            valid_i,
  input  logic [PN_W-1:0]             pn_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o
);
  logic [UNITS-1:0] hit_vec;

  for (genvar g = 0; g < UNITS; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tags_i[g] == pn_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < UNITS; i++)
      if (hit_vec[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
  end

  assign hit_o = |hit_vec;

  // R3
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/pc_victim_sel.sv
`timescale 1ns/1ps
module pc_victim_sel #(
  parameter int UNITS = 4,
  parameter int IDX_W = $clog2(UNITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [UNITS-1:0] valid_i,
  input  logic             alloc_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (alloc_i) ptr_q <= (ptr_q == IDX_W'(UNITS-1)) ? '0 : ptr_q + 1'b1;
  end

  // empty units first, lowest index wins
  always_comb begin
    victim_o = ptr_q;
    for (int i = UNITS-1; i >= 0; i--)
      if (!valid_i[i]) victim_o = IDX_W'(i);
  end

  // R5
  empty_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&valid_i)) |-> !valid_i[victim_o]);
endmodule

// File: rtl/pc_line_store.sv
`timescale 1ns/1ps
module pc_line_store #(
  parameter int UNITS  = 4,
  parameter int OFFS_W = 2,
  parameter int WORD_W = 16,
  parameter int IDX_W  = $clog2(UNITS)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [OFFS_W-1:0] woff_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic [OFFS_W-1:0] roff_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = (1 << IDX_W) << OFFS_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{widx_i, woff_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{ridx_i, roff_i}];
endmodule

// File: rtl/pc_page_cache.sv
`timescale 1ns/1ps
module pc_page_cache
  import pc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int OFFS_W = 2,
  parameter int UNITS  = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_rdata_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int PN_W  = ADDR_W - OFFS_W;
  localparam int WORDS = 1 << OFFS_W;
  localparam int IDX_W = $clog2(UNITS);

  pc_state_e                  state_q;
  logic [UNITS-1:0][PN_W-1:0] tag_q;
  logic [UNITS-1:0]           val_q, dirty_q;
  logic [IDX_W-1:0]           vict_q;
  logic [OFFS_W-1:0]          beat_q;
  logic [PN_W-1:0]            miss_pn_q;
  logic                       replay_q;
  logic                       rsp_valid_q;
  logic [WORD_W-1:0]          rsp_data_q;
  logic [CNT_W-1:0]           hit_cnt_q, miss_cnt_q;

  logic [PN_W-1:0]   req_pn;
  logic [OFFS_W-1:0] req_off;
  logic              hit, acc, miss_start, last_beat, fill_done;
  logic [IDX_W-1:0]  hit_idx, victim;
  logic              st_we;
  logic [IDX_W-1:0]  st_widx, st_ridx;
  logic [OFFS_W-1:0] st_woff, st_roff;
  logic [WORD_W-1:0] st_wdata, st_rdata;

  assign req_pn  = req_addr_i[ADDR_W-1:OFFS_W];
  assign req_off = req_addr_i[OFFS_W-1:0];

  pc_tag_match #(.UNITS(UNITS), .PN_W(PN_W), .IDX_W(IDX_W)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .tags_i(tag_q), .valid_i(val_q),
    .pn_i(req_pn), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  assign last_beat = (beat_q == OFFS_W'(WORDS-1));
  assign fill_done = (state_q == ST_FILL) && mem_rvalid_i && last_beat;

  pc_victim_sel #(.UNITS(UNITS), .IDX_W(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(val_q),
    .alloc_i(fill_done), .victim_o(victim)
  );

  assign req_ready_o = (state_q == ST_IDLE) && hit;
  assign acc         = req_valid_i && req_ready_o;
  assign miss_start  = (state_q == ST_IDLE) && req_valid_i && !hit;

  // single store port shared by hit access, write-back and fill
  assign st_ridx  = (state_q == ST_WB) ? vict_q : hit_idx;
  assign st_roff  = (state_q == ST_WB) ? beat_q : req_off;
  assign st_we    = (acc && req_we_i) || ((state_q == ST_FILL) && mem_rvalid_i);
  assign st_widx  = (state_q == ST_FILL) ? vict_q : hit_idx;
  assign st_woff  = (state_q == ST_FILL) ? beat_q : req_off;
  assign st_wdata = (state_q == ST_FILL) ? mem_rdata_i : req_wdata_i;

  pc_line_store #(.UNITS(UNITS), .OFFS_W(OFFS_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .we_i(st_we), .widx_i(st_widx), .woff_i(st_woff),
    .wdata_i(st_wdata), .ridx_i(st_ridx), .roff_i(st_roff), .rdata_o(st_rdata)
  );

  assign mem_valid_o = (state_q == ST_WB) || (state_q == ST_FREQ);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {tag_q[vict_q], beat_q} : {miss_pn_q, {OFFS_W{1'b0}}};
  assign mem_wdata_o = st_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      val_q       <= '0;
      dirty_q     <= '0;
      vict_q      <= '0;
      beat_q      <= '0;
      miss_pn_q   <= '0;
      replay_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
    end else begin
      rsp_valid_q <= acc;
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            rsp_data_q <= req_we_i ? req_wdata_i : st_rdata;
            if (req_we_i) dirty_q[hit_idx] <= 1'b1;
            if (!replay_q) hit_cnt_q <= hit_cnt_q + 1'b1;
            replay_q <= 1'b0;
          end else if (miss_start) begin
            vict_q     <= victim;
            miss_pn_q  <= req_pn;
            beat_q     <= '0;
            miss_cnt_q <= miss_cnt_q + 1'b1;
            state_q    <= (val_q[victim] && dirty_q[victim]) ? ST_WB : ST_FREQ;
          end
        end
        ST_WB: begin
          if (mem_ready_i) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (mem_ready_i) begin
            beat_q  <= '0;
            state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rvalid_i) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) begin
              tag_q[vict_q]   <= miss_pn_q;
              val_q[vict_q]   <= 1'b1;
              dirty_q[vict_q] <= 1'b0;
              replay_q        <= 1'b1;
              state_q         <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
  assign hit_cnt_o   = hit_cnt_q;
  assign miss_cnt_o  = miss_cnt_q;

  // R4
  fill_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_we_o) |-> (mem_addr_o[OFFS_W-1:0] == '0));
  // R4
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
  // R6
  wr_hit_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_we_i) |=> !mem_valid_o);
  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R9
  hit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hit_cnt_o) |-> (hit_cnt_o == CNT_W'($past(hit_cnt_o) + 1'b1)));
  // R9
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miss_cnt_o) |-> (miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1)));
endmodule

// File: tb/sim_pc_page_cache.sv
`timescale 1ns/1ps
module sim_pc_page_cache;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [7:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic        mem_valid_o, mem_we_o;
  logic        mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [7:0]  mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i = '0;
  logic [15:0] hit_cnt_o, miss_cnt_o;

  pc_page_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  initial forever #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] golden [256];
  logic [15:0] memm   [256];
  int   fifo_q [$];
  bit   dirty_m [64];
  int   exp_hits = 0, exp_misses = 0;
  int   wb_page_exp = -1, wb_beats_exp = 0, wb_beats_seen = 0, fill_cmds = 0;
  bit   rd_pending = 1'b0;
  int   rd_base = 0, rd_beat = 0, cyc = 0;
  bit   held_v = 1'b0;
  logic [7:0] held_addr = '0;
  bit   exp_rsp = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    cyc++;
    if (held_v) chk(mem_valid_o && mem_addr_o == held_addr, "R10 hold", int'(mem_addr_o), int'(held_addr));
    if (rd_pending && (cyc % 4) != 1) begin
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = memm[rd_base + rd_beat];
      rd_beat++;
      if (rd_beat == 4) rd_pending = 1'b0;
    end else mem_rvalid_i = 1'b0;
    mem_ready_i = rst_ni && ((cyc % 3) != 0);
    if (mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        chk(int'(mem_addr_o >> 2) == wb_page_exp, "R7 wb page", int'(mem_addr_o >> 2), wb_page_exp);
        chk(int'(mem_addr_o[1:0]) == wb_beats_seen, "R7 wb order", int'(mem_addr_o[1:0]), wb_beats_seen);
        chk(mem_wdata_o == golden[mem_addr_o], "R7 wb data", int'(mem_wdata_o), int'(golden[mem_addr_o]));
        memm[mem_addr_o] = mem_wdata_o;
        wb_beats_seen++;
      end else begin
        chk(wb_beats_seen == wb_beats_exp, "R7 wb before fill", wb_beats_seen, wb_beats_exp);
        chk(mem_addr_o[1:0] == 2'b00, "R4 fill base", int'(mem_addr_o), int'(mem_addr_o & 8'hFC));
        rd_pending = 1'b1;
        rd_base = int'(mem_addr_o);
        rd_beat = 0;
        fill_cmds++;
      end
    end
    held_v    = mem_valid_o && !mem_ready_i;
    held_addr = mem_addr_o;
  end

  // per-cycle response monitor
  initial forever begin
    @(negedge clk); #1;
    if (rst_ni) chk(rsp_valid_o == exp_rsp, "R3 rsp timing", int'(rsp_valid_o), int'(exp_rsp));
  end

  task automatic do_req(input bit we, input int addr, input logic [15:0] wd);
    int  pn = addr >> 2;
    bit  exp_hit = 1'b0;
    int  stall = 0;
    logic [15:0] exp_data;
    foreach (fifo_q[k]) if (fifo_q[k] == pn) exp_hit = 1'b1;
    if (exp_hit) begin
      exp_hits++;
      wb_beats_exp = 0; wb_page_exp = -1;
    end else begin
      exp_misses++;
      if (fifo_q.size() == 4) begin
        int v = fifo_q.pop_front();
        wb_page_exp  = v;
        wb_beats_exp = dirty_m[v] ? 4 : 0;
        dirty_m[v]   = 1'b0;
      end else begin
        wb_beats_exp = 0; wb_page_exp = -1;
      end
      fifo_q.push_back(pn);
    end
    wb_beats_seen = 0; fill_cmds = 0;
    @(negedge clk);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = 8'(addr); req_wdata_i = wd;
    #0.5;
    while (!req_ready_o && stall < 80) begin
      stall++;
      @(negedge clk); #0.5;
    end
    if (exp_hit) chk(stall == 0, "R3 hit accept", stall, 0);
    else         chk(stall > 0, "R4 miss stall", stall, 1);
    @(posedge clk); exp_rsp = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    exp_data = we ? wd : golden[addr];
    #0.5;
    chk(rsp_valid_o && rsp_rdata_o == exp_data, "R2 data", int'(rsp_rdata_o), int'(exp_data));
    #1 exp_rsp = 1'b0;
    if (we) begin golden[addr] = wd; dirty_m[pn] = 1'b1; end
    if (wb_beats_exp == 0) chk(wb_beats_seen == 0, "R8 clean victim", wb_beats_seen, 0);
    else                   chk(wb_beats_seen == 4, "R7 wb beats", wb_beats_seen, 4);
    chk(fill_cmds == (exp_hit ? 0 : 1), exp_hit ? "R3 no traffic" : "R4 one fill", fill_cmds, exp_hit ? 0 : 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      golden[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      memm[i]   = golden[i];
    end
    for (int i = 0; i < 64; i++) dirty_m[i] = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(hit_cnt_o == 0 && miss_cnt_o == 0, "R1 counters", int'(hit_cnt_o), 0);
    chk(!mem_valid_o && !rsp_valid_o, "R1 idle ports", int'(mem_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 8'h05; #0.5;
    chk(!req_ready_o, "R1 empty misses", int'(req_ready_o), 0);
    req_valid_i = 1'b0;
    @(negedge clk);
    // R4 first miss then R2/R3 hits in page
    do_req(1'b0, 8'h05, '0);
    do_req(1'b0, 8'h04, '0);
    do_req(1'b0, 8'h06, '0);
    do_req(1'b0, 8'h07, '0);
    // R5 remaining empty units
    do_req(1'b0, 8'h09, '0);
    do_req(1'b0, 8'h0E, '0);
    do_req(1'b0, 8'h13, '0);
    // R6 write hit stays local
    do_req(1'b1, 8'h05, 16'hBEEF);
    chk(memm[5] != 16'hBEEF, "R6 memory untouched", int'(memm[5]), int'(golden[5] ^ 16'h0));
    do_req(1'b0, 8'h05, '0);
    // R5 oldest page evicted despite recent hit, R7 dirty write-back
    do_req(1'b0, 8'h16, '0);
    chk(memm[5] == 16'hBEEF, "R7 written back", int'(memm[5]), 16'hBEEF);
    do_req(1'b0, 8'h05, '0);
    chk(miss_cnt_o == 16'(exp_misses), "R5 fifo order", int'(miss_cnt_o), exp_misses);
    // mixed traffic
    for (int i = 0; i < 240; i++) begin
      int a = (i * 37 + i / 3) % 48;
      do_req((i % 5) == 0, a, 16'(i * 16'h0313 + 16'h0077));
    end
    @(negedge clk);
    chk(hit_cnt_o == 16'(exp_hits), "R9 hit count", int'(hit_cnt_o), exp_hits);
    chk(miss_cnt_o == 16'(exp_misses), "R9 miss count", int'(miss_cnt_o), exp_misses);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule